// File: doc/BRIEF.md
# Rate-Paced Sample Streamer for Four DAC Channels

This block reads packed sample bytes from a first-word-fall-through byte FIFO and sends them to four 8-bit DAC channel buses and an 8-bit pin bus. A phase accumulator sets the output rate. On every clock it adds a 32-bit rate word, and each carry out of its top bit produces exactly one output update. In nibble mode a byte gives two updates. Each nibble is widened to 8 bits and sent to all four DAC channels together. In byte mode every update uses one whole byte.

Software hands the block 32-bit commands over a valid/ready handshake. Each command holds a mode bit, a pin-drive bit and a 16-bit update count. A second command can be parked behind the running one. It takes over on the running command's last carry, and the accumulator phase is kept, so the update spacing has no gap. The pin-drive bit only gates the pin bus. The DAC channels receive every sample whatever that bit is set to.

Top module: `nco_nibble_streamer`

## Requirements
- R1: The accumulator adds `freq_word` on every clock while a command runs. Each carry out of bit 31 makes one update, and `dac_stb` pulses high for one cycle with the new data. A rate word of 32'h8000_0000 gives one update every two clocks. A command started from idle begins at phase zero, and its first update comes 1 + g cycles after the accepting edge, where g is the number of additions needed for the first carry.
- R2: A command performs exactly as many updates as the unsigned value in its bits [15:0].
- R3: `cmd_ready` is low while a command waits in the single buffer slot, and a command offered during that time is dropped. The waiting command starts on the running command's last carry. The accumulator is not cleared, so the next update follows the ongoing carry spacing.
- R4: Nibble mode (bit 16 = 0) takes one byte for every two updates, the low nibble first. Each command starts on a fresh byte, and a high nibble left over from the previous command is thrown away.
- R5: In nibble mode a nibble n goes to the DAC as {n, n}, so 4'hF becomes 8'hFF. All four 8-bit lanes of `dac_bus` carry the same value.
- R6: Byte mode (bit 16 = 1) takes one byte per update and puts the full byte on all four DAC lanes and on `pin_out`.
- R7: Bit 23 drives the pins. When it is 1, `pin_oe` = 1 and `pin_out` carries the sample (in nibble mode the nibble sits in bits [3:0] and the upper bits are zero). When it is 0, `pin_oe` = 0 and `pin_out` = 0, and the DAC lanes still take every sample, none forced to zero.
- R8: After the last update, with no command waiting, `busy` drops at the edge of that update. From then on no strobe comes and every output holds its value.
- R9: If the FIFO is empty when a byte is needed, the update still strobes but every data output repeats its previous value. No FIFO read is issued, and `underrun` goes high and stays high until reset.
- R10: After reset `busy`, `dac_stb`, `pin_oe`, `underrun` and `fifo_rd_en` are 0, `dac_bus` and `pin_out` are 0, and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_data | input | 32 | Command: [15:0] count, [16] byte mode, [23] pin drive |
| cmd_ready | output | 1 | Buffer slot free; a command is taken when valid and ready are both high |
| busy | output | 1 | A command is running or waiting |
| freq_word | input | 32 | Rate word added each clock |
| fifo_rd_en | output | 1 | Pop the FIFO head |
| fifo_data | input | 8 | FIFO head byte (show-ahead) |
| fifo_empty | input | 1 | FIFO has no byte |
| dac_bus | output | 32 | Four 8-bit DAC lanes, lane k at [8k+7:8k] |
| dac_stb | output | 1 | One-cycle pulse per update |
| pin_out | output | 8 | Pin data |
| pin_oe | output | 1 | Pin drive enable |
| underrun | output | 1 | Sticky FIFO-starved flag |

## Verification
Every update appears at the clock edge where the accumulator carries. Strobe, DAC lanes and pins change together at that edge and are sampled at the falling edge that follows. The bench runs its own phase accumulator, so it knows each update's due cycle. For a command from idle this is 1 + g cycles after the accepting edge. For every later update it is the number of additions to the next carry after the previous strobe. The monitor measures that spacing against the model value on every update. This includes the switch to a buffered command, where a reset phase would show up as a longer gap. Flags and idle holding are read at falling edges after `busy` has dropped.

// File: rtl/nstr_pkg.sv
package nstr_pkg;

  localparam int CNT_W    = 16;
  localparam int MODE_BIT = 16;
  localparam int PEN_BIT  = 23;

  typedef enum logic {
    SM_NIBBLE = 1'b0,
    SM_BYTE   = 1'b1
  } smode_e;

  typedef struct packed {
    smode_e           mode;
    logic             pen;
    logic [CNT_W-1:0] count;
  } scmd_t;

  function automatic scmd_t cmd_unpack(input logic [31:0] w);
    scmd_t c;
    c.mode  = smode_e'(w[MODE_BIT]);
    c.pen   = w[PEN_BIT];
    c.count = w[CNT_W-1:0];
    return c;
  endfunction

  // nibble replicated into both halves of the DAC byte
  function automatic logic [7:0] nib_to_dac(input logic [3:0] n);
    return {n, n};
  endfunction

  function automatic logic [7:0] nib_to_pins(input logic [3:0] n);
    return {4'b0000, n};
  endfunction

  function automatic logic last_left(input logic [CNT_W-1:0] r);
    return r == {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/nstr_nco.sv
module nstr_nco #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [FW-1:0] freq,
  output logic          carry_tick
);

  logic [FW-1:0] acc;
  logic [FW:0]   sum;

  assign sum        = {1'b0, acc} + {1'b0, freq};
  assign carry_tick = run & sum[FW];

  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (restart) acc <= '0;
    else if (run)     acc <= sum[FW-1:0];
  end

endmodule

// File: rtl/nstr_cmdq.sv
module nstr_cmdq
  import nstr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [31:0] cmd_word,
  input  logic        tick,
  output logic        cmd_ready,
  output logic        busy,
  output logic        act_v,
  output smode_e      act_mode,
  output logic        act_pen,
  output logic        issue,
  output logic        start_fresh
);

  logic             buf_v;
  scmd_t            buf_c;
  logic [CNT_W-1:0] rem;
  logic             accept;
  logic             final_upd;
  logic             handoff;

  assign cmd_ready   = !buf_v;
  assign accept      = cmd_valid && !buf_v;
  assign start_fresh = !act_v && buf_v;
  assign final_upd   = tick && act_v && last_left(rem);
  assign handoff     = final_upd && buf_v;
  assign issue       = start_fresh || handoff;
  assign busy        = act_v || buf_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_v    <= 1'b0;
      buf_c    <= '0;
      act_v    <= 1'b0;
      act_mode <= SM_NIBBLE;
      act_pen  <= 1'b0;
      rem      <= '0;
    end else begin
      if (accept) begin
        buf_v <= 1'b1;
        buf_c <= cmd_unpack(cmd_word);
      end
      if (issue) begin
        buf_v    <= 1'b0;
        act_v    <= 1'b1;
        act_mode <= buf_c.mode;
        act_pen  <= buf_c.pen;
        rem      <= buf_c.count;
      end else if (final_upd) begin
        act_v <= 1'b0;
      end else if (tick) begin
        rem <= rem - 1'b1;
      end
    end
  end

endmodule

// File: rtl/nstr_unpack.sv
module nstr_unpack
  import nstr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  smode_e        mode,
  input  logic          restart,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_rd_en,
  output logic          starve,
  output logic [DW-1:0] upd_dac,
  output logic [DW-1:0] upd_pin
);

  logic          hi_pend;
  logic [DW-1:0] hold;
  logic          need_byte;
  logic [3:0]    nib;

  assign need_byte  = (mode == SM_BYTE) || !hi_pend;
  assign starve     = tick && need_byte && fifo_empty;
  assign fifo_rd_en = tick && need_byte && !fifo_empty;
  assign nib        = hi_pend ? hold[7:4] : fifo_data[3:0];

  always_comb begin
    if (mode == SM_BYTE) begin
      upd_dac = fifo_data;
      upd_pin = fifo_data;
    end else begin
      upd_dac = nib_to_dac(nib);
      upd_pin = nib_to_pins(nib);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_pend <= 1'b0;
      hold    <= '0;
    end else if (restart) begin
      hi_pend <= 1'b0;
    end else if (fifo_rd_en && mode == SM_NIBBLE) begin
      hi_pend <= 1'b1;
      hold    <= fifo_data;
    end else if (tick && mode == SM_NIBBLE && hi_pend) begin
      hi_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/nco_nibble_streamer.sv
module nco_nibble_streamer
  import nstr_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int DAC_W  = 8,
  parameter int N_DAC  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [31:0]            cmd_data,
  output logic                   cmd_ready,
  output logic                   busy,
  input  logic [FREQ_W-1:0]      freq_word,
  output logic                   fifo_rd_en,
  input  logic [DAC_W-1:0]       fifo_data,
  input  logic                   fifo_empty,
  output logic [N_DAC*DAC_W-1:0] dac_bus,
  output logic                   dac_stb,
  output logic [DAC_W-1:0]       pin_out,
  output logic                   pin_oe,
  output logic                   underrun
);

  // named internal events, used by the checker
  logic       upd_tick;
  logic       upd_ok;
  logic       upd_starve;
  logic       upd_nib;
  logic       act_v;
  smode_e     act_mode;
  logic       act_pen;
  logic       issue;
  logic       start_fresh;
  logic [DAC_W-1:0] upd_dac;
  logic [DAC_W-1:0] upd_pin;

  nstr_cmdq u_cmdq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_word   (cmd_data),
    .tick       (upd_tick),
    .cmd_ready  (cmd_ready),
    .busy       (busy),
    .act_v      (act_v),
    .act_mode   (act_mode),
    .act_pen    (act_pen),
    .issue      (issue),
    .start_fresh(start_fresh)
  );

  nstr_nco #(.FW(FREQ_W)) u_nco (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (act_v),
    .restart   (start_fresh),
    .freq      (freq_word),
    .carry_tick(upd_tick)
  );

  nstr_unpack #(.DW(DAC_W)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (upd_tick),
    .mode      (act_mode),
    .restart   (issue),
    .fifo_empty(fifo_empty),
    .fifo_data (fifo_data),
    .fifo_rd_en(fifo_rd_en),
    .starve    (upd_starve),
    .upd_dac   (upd_dac),
    .upd_pin   (upd_pin)
  );

  assign upd_ok  = upd_tick && !upd_starve;
  assign upd_nib = (act_mode == SM_NIBBLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_stb  <= 1'b0;
      pin_out  <= '0;
      pin_oe   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      dac_stb <= upd_tick;
      if (upd_ok) begin
        pin_oe  <= act_pen;
        pin_out <= act_pen ? upd_pin : '0;
      end
      if (upd_starve) underrun <= 1'b1;
    end
  end

  for (genvar k = 0; k < N_DAC; k++) begin : g_lane
    logic [DAC_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)      lane_q <= '0;
      else if (upd_ok) lane_q <= upd_dac;
    end
    assign dac_bus[k*DAC_W +: DAC_W] = lane_q;
  end

endmodule

// File: rtl/nstr_chk.sv
module nstr_chk #(
  parameter int FREQ_W = 32,
  parameter int DAC_W  = 8,
  parameter int N_DAC  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic                   busy,
  input logic [FREQ_W-1:0]      freq_word,
  input logic                   fifo_rd_en,
  input logic                   fifo_empty,
  input logic [N_DAC*DAC_W-1:0] dac_bus,
  input logic                   dac_stb,
  input logic [DAC_W-1:0]       pin_out,
  input logic                   pin_oe,
  input logic                   underrun,
  input logic                   upd_ok,
  input logic                   upd_nib,
  input logic                   act_pen
);

  p_pace_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_stb && !freq_word[FREQ_W-1]) |=> (!dac_stb || !$stable(freq_word)));

  p_buffer_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_widen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ok && upd_nib) |=> (dac_bus[DAC_W-1:DAC_W/2] == dac_bus[DAC_W/2-1:0]));

  for (genvar k = 1; k < N_DAC; k++) begin : g_lane_chk
    p_lane_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dac_stb |-> (dac_bus[k*DAC_W +: DAC_W] == dac_bus[DAC_W-1:0]));
  end

  p_pins_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ok && !act_pen) |=> (pin_out == '0 && !pin_oe));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !dac_stb);

  p_read_needs_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> !fifo_empty);

  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

endmodule

bind nco_nibble_streamer nstr_chk #(
  .FREQ_W(FREQ_W), .DAC_W(DAC_W), .N_DAC(N_DAC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .freq_word (freq_word),
  .fifo_rd_en(fifo_rd_en),
  .fifo_empty(fifo_empty),
  .dac_bus   (dac_bus),
  .dac_stb   (dac_stb),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .underrun  (underrun),
  .upd_ok    (upd_ok),
  .upd_nib   (upd_nib),
  .act_pen   (act_pen)
);

// File: tb/sim_nco_nibble_streamer.sv
module sim_nco_nibble_streamer;

  localparam int WD_LIMIT = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid;
  logic [31:0] cmd_data;
  logic        cmd_ready;
  logic        busy;
  logic [31:0] freq_word;
  logic        fifo_rd_en;
  logic [7:0]  fifo_data;
  logic        fifo_empty;
  logic [31:0] dac_bus;
  logic        dac_stb;
  logic [7:0]  pin_out;
  logic        pin_oe;
  logic        underrun;

  always #2 clk = ~clk;

  nco_nibble_streamer u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .busy(busy), .freq_word(freq_word),
    .fifo_rd_en(fifo_rd_en), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .dac_bus(dac_bus), .dac_stb(dac_stb), .pin_out(pin_out), .pin_oe(pin_oe),
    .underrun(underrun)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // show-ahead FIFO model
  logic [7:0] fmem [0:255];
  int wr_p = 0;
  int rd_p = 0;
  assign fifo_empty = (rd_p == wr_p);
  assign fifo_data  = fmem[rd_p[7:0]];
  always @(posedge clk) if (fifo_rd_en) rd_p <= rd_p + 1;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard model
  typedef struct {
    logic [7:0] dac;
    logic [7:0] pin;
    logic       oe;
    int         gap;
    bit         from_acc;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  logic [7:0] mq[$];
  bit         m_hi;
  logic [7:0] m_hold;
  logic [7:0] m_dac = 8'h00;
  logic [7:0] m_pin = 8'h00;
  bit         m_oe = 1'b0;
  longint     m_ph = 0;
  longint     m_freq = 1;
  int         acc_cyc = 0;

  function automatic int next_gap();
    int g = 0;
    do begin
      m_ph = m_ph + m_freq;
      g++;
    end while (m_ph < 64'h1_0000_0000);
    m_ph = m_ph - 64'h1_0000_0000;
    return g;
  endfunction

  function automatic logic [31:0] mk(input bit byte_mode, input bit pen, input int n);
    return (32'(pen) << 23) | (32'(byte_mode) << 16) | 32'(n[15:0]);
  endfunction

  task automatic model_cmd(input logic [31:0] c, input bit cont, input string tag);
    bit   bm = c[16];
    bit   pen = c[23];
    int   n = int'(c[15:0]);
    logic [7:0] b;
    logic [3:0] nb;
    exp_t e;
    m_hi = 1'b0;
    if (!cont) m_ph = 0;
    for (int i = 0; i < n; i++) begin
      int g = next_gap();
      e.from_acc = (!cont && i == 0);
      e.gap = e.from_acc ? g + 1 : g;
      e.tag = tag;
      if ((bm || !m_hi) && mq.size() == 0) begin
        // starved: everything repeats
      end else if (bm) begin
        b = mq.pop_front();
        m_dac = b; m_pin = pen ? b : 8'h00; m_oe = pen;
      end else begin
        if (m_hi) begin
          nb = m_hold[7:4];
          m_hi = 1'b0;
        end else begin
          b = mq.pop_front();
          m_hold = b;
          m_hi = 1'b1;
          nb = b[3:0];
        end
        m_dac = {nb, nb}; m_pin = pen ? {4'h0, nb} : 8'h00; m_oe = pen;
      end
      e.dac = m_dac; e.pin = m_pin; e.oe = m_oe;
      exp_q.push_back(e);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    fmem[wr_p[7:0]] = b;
    wr_p = wr_p + 1;
    mq.push_back(b);
  endtask

  task automatic set_rate(input logic [31:0] f);
    @(negedge clk);
    freq_word = f;
    m_freq = longint'(f);
  endtask

  task automatic send_cmd(input logic [31:0] c, input bit cont, input string tag);
    model_cmd(c, cont, tag);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = c;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!cont) acc_cyc = cyc;
  endtask

  task automatic wait_idle();
    while (busy || exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor
  int last_stb = 0;
  int n_stb = 0;
  exp_t me;
  int mg;
  always @(negedge clk) begin
    if (rst_n && dac_stb) begin
      n_stb++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "update with nothing expected", dac_bus, 0);
      end else begin
        me = exp_q.pop_front();
        for (int k = 0; k < 4; k++)
          chk(dac_bus[k*8 +: 8] == me.dac, me.tag, $sformatf("dac lane %0d", k),
              dac_bus[k*8 +: 8], me.dac);
        chk(pin_out == me.pin, me.tag, "pin_out", pin_out, me.pin);
        chk(pin_oe == me.oe, me.tag, "pin_oe", pin_oe, me.oe);
        mg = me.from_acc ? cyc - acc_cyc : cyc - last_stb;
        chk(mg == me.gap, "R1", "update spacing", mg, me.gap);
      end
      last_stb = cyc;
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (cyc > WD_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  int n0;
  logic [31:0] snap;

  initial begin
    for (int i = 0; i < 256; i++) fmem[i] = 8'h00;
    cmd_valid = 1'b0;
    cmd_data  = '0;
    freq_word = 32'h8000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(busy == 0, "R10", "busy", busy, 0);
    chk(cmd_ready == 1, "R10", "cmd_ready", cmd_ready, 1);
    chk(dac_bus == 0, "R10", "dac_bus", dac_bus, 0);
    chk(pin_out == 0 && pin_oe == 0, "R10", "pins", {pin_oe, pin_out}, 0);
    chk(underrun == 0 && dac_stb == 0 && fifo_rd_en == 0, "R10", "flags",
        {underrun, dac_stb, fifo_rd_en}, 0);

    // R4/R5/R7: nibble mode, pins driven, half rate (R1)
    set_rate(32'h8000_0000);
    put_byte(8'h10); put_byte(8'h32); put_byte(8'h54); put_byte(8'h76);
    n0 = n_stb;
    send_cmd(mk(0, 1, 8), 0, "R4");
    wait_idle();
    chk(n_stb - n0 == 8, "R2", "update count", n_stb - n0, 8);
    // R8: idle hold
    snap = dac_bus;
    n0 = n_stb;
    repeat (20) @(negedge clk);
    chk(busy == 0, "R8", "busy after run", busy, 0);
    chk(dac_bus == snap && snap == 32'h7777_7777, "R8", "dac hold", dac_bus, 32'h7777_7777);
    chk(n_stb == n0, "R8", "no strobes when idle", n_stb - n0, 0);

    // R7: pins off, DAC still fed every nibble
    set_rate(32'h4000_0000);
    put_byte(8'hA5); put_byte(8'hF0); put_byte(8'h3C);
    send_cmd(mk(0, 0, 6), 0, "R7");
    wait_idle();

    // R6: byte mode at near full rate
    set_rate(32'hFFFF_FFFF);
    put_byte(8'h81); put_byte(8'h7E); put_byte(8'hC3);
    n0 = n_stb;
    send_cmd(mk(1, 1, 3), 0, "R6");
    wait_idle();
    chk(n_stb - n0 == 3, "R2", "byte mode count", n_stb - n0, 3);

    // R3: buffered handoff, phase kept, fresh byte, dropped offer
    set_rate(32'h5000_0000);
    put_byte(8'h21); put_byte(8'h43); put_byte(8'h65); put_byte(8'h87);
    send_cmd(mk(0, 1, 3), 0, "R4");
    send_cmd(mk(0, 0, 4), 1, "R3");
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = mk(0, 1, 5);
    chk(cmd_ready == 0, "R3", "ready while slot full", cmd_ready, 0);
    @(negedge clk);
    chk(cmd_ready == 0, "R3", "ready while slot full", cmd_ready, 0);
    cmd_valid = 1'b0;
    wait_idle();
    repeat (12) @(negedge clk);
    chk(busy == 0, "R3", "dropped offer left no work", busy, 0);

    // R9: starvation
    chk(underrun == 0, "R9", "flag before starvation", underrun, 0);
    set_rate(32'h8000_0000);
    send_cmd(mk(0, 1, 2), 0, "R9");
    wait_idle();
    chk(underrun == 1, "R9", "flag after starvation", underrun, 1);
    put_byte(8'h9B);
    send_cmd(mk(0, 1, 2), 0, "R9");
    wait_idle();
    chk(underrun == 1, "R9", "flag stays set", underrun, 1);
    chk(rd_p == wr_p, "R9", "all bytes consumed", rd_p, wr_p);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule